// File: doc/BRIEF.md
# Four-Channel Edge/Center-Aligned PWM Timer

This block drives four PWM outputs from one shared 16-bit counter. Software reaches it through a small register port and programs three things: the counter's start value, its modulo, and one compare value per channel. The counter either counts up and reloads, which gives edge-aligned waveforms, or counts up and then back down, which gives center-aligned waveforms. Each channel compares the counter with its own value and drives a high-true or low-true output.

The counter advances on a tick. A tick comes from one of three sources: the system clock, a fixed-rate enable pulse or an external enable pulse. It then passes through a power-of-two prescaler. Selecting no source freezes the counter where it stands, and the outputs hold with it. The modulo and the channel compare values are double-buffered: a new value is copied into the working copy only when a PWM period ends. Each output can be masked so that it shows a programmed idle level instead of its waveform.

The counter is a three-state machine. `ST_IDLE` is the state after reset, before the first tick. `ST_UP` is counting up. `ST_DOWN` is counting down and is used in center-aligned mode only. The transitions are:
- `ST_IDLE` to `ST_UP` on the first tick. This loads the start value and the buffers.
- `ST_UP` to `ST_UP` with a reload at the modulo in edge-aligned mode.
- `ST_UP` to `ST_DOWN` at the modulo in center-aligned mode.
- `ST_DOWN` to `ST_UP` when the count returns to the start value, or at once if edge-aligned mode is selected while counting down.

Each return to the start value ends a period and refreshes the buffers.

Top module: `pwm_timer`

## Requirements
- R1: After reset, the control register reads 0 (no clock source), the mask register reads 0xF with every channel masked, the counter reads 0 and every output is 0.
- R2: Control bits 4:3 pick the tick source. The codes are 00 = stopped, 01 = every system clock, 10 = `fixed_tick` pulses and 11 = `ext_tick` pulses. The pulse input of the source that is not selected has no effect.
- R3: Control bits 2:0 hold a value n. The counter advances once every 2^n source ticks.
- R4: When control bit 5 is 0 (edge-aligned), the counter runs from the start value up to the modulo and then reloads. The period is modulo − start + 1 ticks. The active time is compare − start ticks, so a compare value above the modulo gives 100% and a compare value equal to the start value gives 0%.
- R5: When control bit 5 is 1 (center-aligned), the counter runs up from the start value to the modulo and back down. The period is 2·(modulo − start) ticks. The active time is 2·(compare − start) ticks: the output goes inactive at the compare match while counting up and becomes active again at the match while counting down.
- R6: In a channel control register, bit 5 enables PWM, bit 3 selects a high-true output and bit 2 selects a low-true output, which is the inverted waveform. An unmasked channel with bit 5 clear, or with neither polarity bit set, outputs 0.
- R7: A 1 in bit i of the mask register forces output i to bit i of the idle-level register. Unmasked channels are unaffected.
- R8: Writes to the modulo and to the compare values take effect at the end of the period in progress, never part-way through one.
- R9: While the clock source is 00, the counter and all the outputs hold their values.
- R10: The register addresses are:
  - 0: control
  - 1: counter (read-only)
  - 2: modulo
  - 3: start value
  - 4: mask
  - 5: idle levels
  - 8+i: channel i control
  - 16+i: channel i compare

  The modulo and compare addresses read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| fixed_tick | input | 1 | Single-cycle enable pulse from the fixed-rate source |
| ext_tick | input | 1 | Single-cycle enable pulse from the external source |
| pwm_out | output | 4 | Channel outputs |

## Verification
The bench measures active time over one full period window, so its checks do not depend on phase. It covers the compare-equals-start and compare-above-modulo corners: a design with an off-by-one in its compare gives 1 or 9 counts where 0 or 10 are expected. In center-aligned mode it uses the same window to catch a design that uses one comparison for both count directions, which loses one tick of active time per period. It lowers the modulo in the middle of a period and checks that the counter still reaches the old modulo once; an unbuffered design reloads early. It also measures the period between rising edges with the prescaler and with each pulse source, and confirms that freezing holds both the counter and the outputs.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    localparam int CTL_W      = 6;
    localparam int CENTER_BIT = 5;
    localparam int CLK_LO     = 3;
    localparam int CH_EN_BIT  = 5;
    localparam int CH_HI_BIT  = 3;
    localparam int CH_LO_BIT  = 2;

    localparam logic [1:0] SRC_OFF = 2'b00;
    localparam logic [1:0] SRC_SYS = 2'b01;
    localparam logic [1:0] SRC_FIX = 2'b10;
    localparam logic [1:0] SRC_EXT = 2'b11;

    localparam int A_CTRL   = 0;
    localparam int A_CNT    = 1;
    localparam int A_MOD    = 2;
    localparam int A_INIT   = 3;
    localparam int A_MASK   = 4;
    localparam int A_OINIT  = 5;
    localparam int A_CH_CTL = 8;
    localparam int A_CH_VAL = 16;
endpackage

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale
    import pwm_timer_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      clk_sel,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            fixed_tick,
    input  logic            ext_tick,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] lim;
    logic             src_en;

    always_comb begin
        unique case (clk_sel)
            SRC_OFF: src_en = 1'b0;
            SRC_SYS: src_en = 1'b1;
            SRC_FIX: src_en = fixed_tick;
            SRC_EXT: src_en = ext_tick;
        endcase
    end

    assign lim  = ~({DIV_W{1'b1}} << ps_sel);
    assign tick = src_en && (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else if (src_en) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_shadow,
    output logic [CNT_W-1:0] cnt_q,
    output cnt_state_e       state_q,
    output logic             load,
    output logic [CNT_W-1:0] mod_act
);
    cnt_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_base;

    // one step above the start value: the next step down closes the period
    assign at_base = ({1'b0, cnt_q} <= ({1'b0, init_val} + 1'b1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d   = init_val;
                    state_d = ST_UP;
                    load    = 1'b1;
                end
                ST_UP: begin
                    if (cnt_q >= mod_act) begin
                        if (center && (mod_act > init_val) && !at_base) begin
                            cnt_d   = cnt_q - 1'b1;
                            state_d = ST_DOWN;
                        end else begin
                            cnt_d = init_val;
                            load  = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (!center || at_base) begin
                        cnt_d   = init_val;
                        state_d = ST_UP;
                        load    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mod_act <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                mod_act <= mod_shadow;
            end
        end
    end
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic             down,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cv_shadow,
    input  logic             en,
    input  logic             hi,
    input  logic             lo,
    output logic             lvl_q
);
    logic [CNT_W-1:0] cv_act;
    logic             active;
    logic             lvl_d;

    // counting down the match sets the output, counting up it clears it
    assign active = down ? (cnt_q <= cv_act) : (cnt_q < cv_act);
    assign lvl_d  = en & (hi ? active : (lo & ~active));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_act <= '0;
            lvl_q  <= 1'b0;
        end else begin
            if (load) begin
                cv_act <= cv_shadow;
            end
            if (adv) begin
                lvl_q <= lvl_d;
            end
        end
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              fixed_tick,
    input  logic              ext_tick,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [CTL_W-1:0]  ctrl_q;
    logic [CNT_W-1:0]  mod_sh;
    logic [CNT_W-1:0]  init_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] oinit_q;
    logic [CTL_W-1:0]  chctl_q [NUM_CH];
    logic [CNT_W-1:0]  cv_sh   [NUM_CH];

    logic [1:0]        clk_sel;
    logic [PS_W-1:0]   ps_sel;
    logic              center;
    logic              tick;
    logic              adv_q;
    logic              load;
    cnt_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  mod_act;
    logic [NUM_CH-1:0] lvl;

    assign clk_sel = ctrl_q[CLK_LO+1:CLK_LO];
    assign ps_sel  = ctrl_q[PS_W-1:0];
    assign center  = ctrl_q[CENTER_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mod_sh  <= '1;
            init_q  <= '0;
            mask_q  <= '1;
            oinit_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                chctl_q[i] <= '0;
                cv_sh[i]   <= '0;
            end
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(A_CTRL):  ctrl_q  <= wdata[CTL_W-1:0];
                ADDR_W'(A_MOD):   mod_sh  <= wdata;
                ADDR_W'(A_INIT):  init_q  <= wdata;
                ADDR_W'(A_MASK):  mask_q  <= wdata[NUM_CH-1:0];
                ADDR_W'(A_OINIT): oinit_q <= wdata[NUM_CH-1:0];
                default: ;
            endcase
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(A_CH_CTL + i)) chctl_q[i] <= wdata[CTL_W-1:0];
                if (addr == ADDR_W'(A_CH_VAL + i)) cv_sh[i]   <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CTRL):  rdata = CNT_W'(ctrl_q);
            ADDR_W'(A_CNT):   rdata = cnt_q;
            ADDR_W'(A_MOD):   rdata = mod_sh;
            ADDR_W'(A_INIT):  rdata = init_q;
            ADDR_W'(A_MASK):  rdata = CNT_W'(mask_q);
            ADDR_W'(A_OINIT): rdata = CNT_W'(oinit_q);
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(A_CH_CTL + i)) rdata = CNT_W'(chctl_q[i]);
            if (addr == ADDR_W'(A_CH_VAL + i)) rdata = cv_sh[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adv_q <= 1'b0;
        else        adv_q <= tick;
    end

    pwm_timer_prescale #(.PS_W(PS_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .ps_sel     (ps_sel),
        .fixed_tick (fixed_tick),
        .ext_tick   (ext_tick),
        .tick       (tick)
    );

    pwm_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .center     (center),
        .init_val   (init_q),
        .mod_shadow (mod_sh),
        .cnt_q      (cnt_q),
        .state_q    (state_q),
        .load       (load),
        .mod_act    (mod_act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_timer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (adv_q),
            .load      (load),
            .down      (state_q == ST_DOWN),
            .cnt_q     (cnt_q),
            .cv_shadow (cv_sh[g]),
            .en        (chctl_q[g][CH_EN_BIT]),
            .hi        (chctl_q[g][CH_HI_BIT]),
            .lo        (chctl_q[g][CH_LO_BIT]),
            .lvl_q     (lvl[g])
        );
        assign pwm_out[g] = mask_q[g] ? oinit_q[g] : lvl[g];
    end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load,
    input logic [1:0]       clk_sel,
    input logic [PS_W-1:0]  ps_sel,
    input logic             center,
    input logic [CNT_W-1:0] cnt_q,
    input cnt_state_e       state_q,
    input logic [CNT_W-1:0] mod_act
);
    AST_FREEZE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SRC_OFF) |=> $stable(cnt_q)); // R9

    AST_PS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_sel != '0) |=> !tick); // R3

    AST_MOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mod_act)); // R8

    AST_DOWN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && $past(state_q) != ST_DOWN) |-> $past(center)); // R5

    AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && state_q == ST_UP && cnt_q < mod_act)
        |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (load),
    .clk_sel (clk_sel),
    .ps_sel  (ps_sel),
    .center  (center),
    .cnt_q   (cnt_q),
    .state_q (state_q),
    .mod_act (mod_act)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        fixed_tick;
    logic        ext_tick;
    logic [3:0]  pwm_out;

    int checks;
    int fails;
    int fix_div;
    int ext_div;

    localparam logic [15:0] CH_HI = 16'h0028; // bit5 PWM + bit3 high-true
    localparam logic [15:0] CH_LO = 16'h0024; // bit5 PWM + bit2 low-true

    pwm_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .fixed_tick (fixed_tick),
        .ext_tick   (ext_tick),
        .pwm_out    (pwm_out)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    // pulse sources, driven away from the active edge
    initial begin
        int fph;
        int eph;
        fph = 0;
        eph = 0;
        fixed_tick = 1'b0;
        ext_tick   = 1'b0;
        forever begin
            @(negedge clk);
            if (fix_div > 0) begin
                fph = (fph + 1) % fix_div;
                fixed_tick = (fph == 0);
            end else begin
                fixed_tick = 1'b0;
            end
            if (ext_div > 0) begin
                eph = (eph + 1) % ext_div;
                ext_tick = (eph == 0);
            end else begin
                ext_tick = 1'b0;
            end
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        addr  = 5'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 5'(a);
        #1 d = int'(rdata);
    endtask

    task automatic count_high(input int ch, input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) n++;
        end
    endtask

    task automatic rise_gap(input int ch, output int gap);
        logic prev;
        int   t;
        gap = -1;
        @(negedge clk);
        prev = pwm_out[ch];
        t = 0;
        while (t < 2000 && !(pwm_out[ch] && !prev)) begin
            prev = pwm_out[ch];
            @(negedge clk);
            t++;
        end
        for (int i = 1; i < 2000; i++) begin
            prev = pwm_out[ch];
            @(negedge clk);
            if (pwm_out[ch] && !prev) begin
                gap = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        int v;
        rd(0, v);  chk_eq("R1 control after reset", v, 0);
        rd(4, v);  chk_eq("R1 mask after reset", v, 15);
        rd(1, v);  chk_eq("R1 counter after reset", v, 0);
        chk_eq("R1 outputs after reset", int'(pwm_out), 0);
    endtask

    task automatic t_edge();
        int n;
        int v;
        wr(3, 16'd0);
        wr(2, 16'd9);
        wr(8, CH_HI);  wr(16, 16'd3);
        wr(9, CH_LO);  wr(17, 16'd0);
        wr(10, CH_HI); wr(18, 16'd10);
        wr(11, CH_LO); wr(19, 16'd5);
        rd(2, v);  chk_eq("R10 modulo readback", v, 9);
        rd(18, v); chk_eq("R10 compare readback", v, 10);
        wr(4, 16'h0);
        wr(0, 16'h0008);
        repeat (60) @(negedge clk);
        count_high(0, 10, n); chk_eq("R4 edge compare 3 active", n, 3);
        count_high(1, 10, n); chk_eq("R6 low-true compare=start 0% gives steady 1", n, 10);
        count_high(2, 10, n); chk_eq("R4 compare above modulo 100%", n, 10);
        count_high(3, 10, n); chk_eq("R6 low-true compare 5 inverted", n, 5);
        rise_gap(0, n);       chk_eq("R4 edge period mod+1", n, 10);
    endtask

    task automatic t_disable();
        int n;
        wr(11, 16'h0004);
        repeat (5) @(negedge clk);
        count_high(3, 10, n); chk_eq("R6 PWM enable clear gives 0", n, 0);
        wr(11, CH_LO);
    endtask

    task automatic t_init();
        int n;
        wr(3, 16'd4);
        wr(2, 16'd11);
        wr(16, 16'd6);
        repeat (80) @(negedge clk);
        count_high(0, 8, n); chk_eq("R4 start value 4 compare 6 active", n, 2);
        rise_gap(0, n);      chk_eq("R4 period with start value", n, 8);
        wr(3, 16'd0);
        wr(2, 16'd9);
        wr(16, 16'd3);
        repeat (60) @(negedge clk);
    endtask

    task automatic t_center();
        int n;
        wr(2, 16'd8);
        wr(0, 16'h0028);
        repeat (100) @(negedge clk);
        count_high(0, 16, n); chk_eq("R5 center compare 3 active 6", n, 6);
        count_high(1, 16, n); chk_eq("R5 center compare=start low-true steady", n, 16);
        count_high(2, 16, n); chk_eq("R5 center compare above modulo 100%", n, 16);
        rise_gap(0, n);       chk_eq("R5 center period 2*(mod-start)", n, 16);
        wr(3, 16'd2);
        wr(16, 16'd5);
        repeat (100) @(negedge clk);
        count_high(0, 12, n); chk_eq("R5 center start 2 compare 5", n, 6);
        wr(0, 16'h0008);
        wr(3, 16'd0);
        wr(2, 16'd9);
        wr(16, 16'd3);
        repeat (80) @(negedge clk);
    endtask

    task automatic t_buffer();
        int v;
        int mx;
        int guard;
        v = -1;
        guard = 0;
        while (v != 2 && guard < 100) begin
            rd(1, v);
            guard++;
        end
        wr(2, 16'd4);
        mx = 0;
        v = 1;
        guard = 0;
        while (v != 0 && guard < 100) begin
            rd(1, v);
            if (v > mx) mx = v;
            guard++;
        end
        chk_eq("R8 old modulo finishes current period", mx, 9);
        mx = 0;
        for (int i = 0; i < 10; i++) begin
            rd(1, v);
            if (v > mx) mx = v;
        end
        chk_eq("R8 new modulo after period end", mx, 4);
        wr(2, 16'd9);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_prescale();
        int n;
        wr(0, 16'h000A);
        repeat (100) @(negedge clk);
        rise_gap(0, n);       chk_eq("R3 divide-by-4 period", n, 40);
        count_high(0, 40, n); chk_eq("R3 divide-by-4 active", n, 12);
    endtask

    task automatic t_sources();
        int n;
        fix_div = 3;
        ext_div = 1;
        wr(0, 16'h0010);
        repeat (100) @(negedge clk);
        rise_gap(0, n); chk_eq("R2 fixed source, external ignored", n, 30);
        ext_div = 2;
        wr(0, 16'h0018);
        repeat (100) @(negedge clk);
        rise_gap(0, n); chk_eq("R2 external source, fixed ignored", n, 20);
        fix_div = 0;
        ext_div = 0;
        wr(0, 16'h0008);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_mask();
        int n;
        wr(5, 16'h1);
        wr(4, 16'h1);
        count_high(0, 10, n); chk_eq("R7 masked to idle 1", n, 10);
        count_high(1, 10, n); chk_eq("R7 unmasked channel unaffected", n, 10);
        wr(5, 16'h0);
        count_high(0, 10, n); chk_eq("R7 masked to idle 0", n, 0);
        wr(4, 16'h0);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_freeze();
        int c0;
        int c1;
        logic [3:0] o0;
        wr(0, 16'h0000);
        repeat (3) @(negedge clk);
        rd(1, c0);
        o0 = pwm_out;
        repeat (20) @(negedge clk);
        rd(1, c1);
        chk_eq("R9 counter holds when stopped", c1, c0);
        chk_eq("R9 outputs hold when stopped", int'(pwm_out), int'(o0));
    endtask

    initial begin
        checks  = 0;
        fails   = 0;
        fix_div = 0;
        ext_div = 0;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        addr    = '0;
        wdata   = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_disable();
        t_init();
        t_center();
        t_buffer();
        t_prescale();
        t_sources();
        t_mask();
        t_freeze();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule